// File: doc/BRIEF.md
# Protected SRAM access controller

This block is a bus slave that places a 32-bit configuration register in front of a small on-chip RAM. The RAM is split into four equal protection blocks. Each request carries a write flag, an instruction-fetch flag, a protected-mode (relocate) flag and a freeze flag. The block decodes the word address as an array word, the configuration register, or an unmapped location. It finishes every access with a one-cycle ready pulse, and an error flag goes out in the same cycle when the access is refused.

The configuration register holds three controls. A write lock freezes the register's contents. An array disable refuses all array traffic and acts as the low-power state. A two-cycle mode spends one cycle on decode and a second cycle on the access. Each block also has a read-only bit and a data-only bit. These bits take effect only when the requester raises its protected-mode flag. In simulation each block has `2**BLK_AW` words, so the array spans word addresses `0 .. 4*2**BLK_AW-1` and the register sits at word address `4*2**BLK_AW`.

Top module: `prot_sram_ctrl`

## Requirements
- R1: With the lock bit clear, a register write stores the written value masked to the defined fields, which are bit 31 lock, bit 30 disable, bit 29 two-cycle, bits 7:4 read-only for blocks 3..0 and bits 3:0 data-only for blocks 3..0. All other bits read back as 0.
- R2: With the lock bit set, a register write leaves every bit 30:0 unchanged and completes with ready and no error.
- R3: Once the lock bit is set, a write without freeze cannot clear it. A write with freeze high and written bit 31 equal to 0 clears only the lock bit.
- R4: With the disable bit set, every array read and write gets an error and leaves the array unchanged, while register accesses still complete normally. Clearing the bit restores array access.
- R5: With two-cycle clear, ready rises in the cycle after the request edge. With two-cycle set, ready rises one cycle later than that. This applies to register and array accesses alike.
- R6: The protection block of an array word is address bits `[BLK_AW+1:BLK_AW]`. Block 0 holds the lowest addresses and is governed by bit 0 of each 4-bit protection field.
- R7: An array write gets an error only when the relocate flag and the addressed block's read-only bit are both 1.
- R8: An instruction fetch (read with the fetch flag) gets an error only when the relocate flag and the addressed block's data-only bit are both 1. Data reads are never refused by the data-only bit.
- R9: An errored array write does not change the array. Read data is 0 for writes and for errored accesses.
- R10: Reset clears all register bits, giving an unlocked, enabled, one-cycle, unprotected state, and re-enables a disabled array.
- R11: An access to an address above the register gets an error.
- R12: The error flag is only ever high together with ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Access request, one cycle wide, issued only with no access pending |
| we_i | input | 1 | 1 = write, 0 = read |
| ifetch_i | input | 1 | Read is an instruction fetch |
| reloc_i | input | 1 | Requester is in protected (relocate) mode |
| frz_i | input | 1 | Requester is in freeze (debug) mode |
| addr_i | input | BLK_AW+3 | Word address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid with ready |
| rdy_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Access refused, high only with ready |

## Verification
Array traffic is driven with every combination of the relocate flag, write, data read and instruction fetch against blocks that carry a read-only bit, a data-only bit or neither. This separates an error caused by the wrong protection bit, or by the wrong block, from an error that is correctly gated by the relocate flag. Data-only and read-only bits are also placed on block 0 and block 3 and probed at the block edges, which exposes a reversed or shifted block index. Register writes are issued locked and unlocked, with and without freeze, and with lock set or clear in the written data. Two-cycle mode is exercised on register, array and unmapped accesses.

// File: rtl/psc_pkg.sv
// Package: shared constants and types for the protected SRAM access controller.
// Assumes a 32-bit data path and exactly four protection blocks.
package psc_pkg;
    localparam int DATA_W = 32;
    localparam int NBLK   = 4;
    localparam int LOCK_B = 31;
    localparam int DIS_B  = 30;
    localparam int TWO_B  = 29;
    localparam int RO_LSB = 4;
    localparam int DO_LSB = 0;
    localparam logic [DATA_W-1:0] CFG_MASK = 32'hE000_00FF;

    typedef enum logic [1:0] {
        TGT_ARR  = 2'd0,
        TGT_REG  = 2'd1,
        TGT_NONE = 2'd2
    } tgt_e;

    typedef struct packed {
        logic we;
        logic ifetch;
        logic reloc;
        logic frz;
    } acc_attr_t;
endpackage

// File: rtl/psc_cfg_reg.sv
// Configuration register with write lock.
// Assumes wr_en is a single-cycle strobe and frz is sampled with it.
// Reserved bits are masked to zero on every write.
module psc_cfg_reg
    import psc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              frz,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] cfg_q
);
    // Update the register: free when unlocked, only lock release in freeze when locked.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            if (!cfg_q[LOCK_B]) begin
                cfg_q <= wdata & CFG_MASK;
            end else if (frz && !wdata[LOCK_B]) begin
                cfg_q[LOCK_B] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/psc_guard.sv
// Address decode and protection check, purely combinational.
// Assumes word addressing: array below 4*2**BLK_AW, register at exactly that address.
module psc_guard
    import psc_pkg::*;
#(
    parameter int BLK_AW = 4,
    localparam int ADDR_W = BLK_AW + 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    input  logic              ifetch,
    input  logic              reloc,
    input  logic              dis,
    input  logic [NBLK-1:0]   ro_bits,
    input  logic [NBLK-1:0]   do_bits,
    output tgt_e              tgt,
    output logic              err,
    output logic              arr_wr,
    output logic              reg_wr
);
    localparam logic [ADDR_W-1:0] REG_ADDR = ADDR_W'(NBLK << BLK_AW);

    logic [1:0] blk;
    logic       ro_hit;
    logic       do_hit;

    // Classify the address and pick the protection block.
    always_comb begin
        if (addr < REG_ADDR)       tgt = TGT_ARR;
        else if (addr == REG_ADDR) tgt = TGT_REG;
        else                       tgt = TGT_NONE;
        blk = addr[BLK_AW +: 2];
    end

    // Evaluate protection and derive the error and write strobes.
    always_comb begin
        ro_hit = reloc & we & ro_bits[blk];
        do_hit = reloc & ~we & ifetch & do_bits[blk];
        err    = (tgt == TGT_NONE) || ((tgt == TGT_ARR) && (dis | ro_hit | do_hit));
        arr_wr = (tgt == TGT_ARR) && !err && we;
        reg_wr = (tgt == TGT_REG) && we;
    end
endmodule

// File: rtl/psc_array.sv
// Behavioural word array: synchronous write, combinational read, no reset.
// Assumes the caller gates wr_en with all protection checks.
module psc_array
    import psc_pkg::*;
#(
    parameter int AW = 6,
    localparam int DEPTH = 1 << AW
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [AW-1:0]     addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem [DEPTH];

    // Store one word on a permitted write.
    always_ff @(posedge clk) begin
        if (wr_en) mem[addr] <= wdata;
    end

    // Present the addressed word.
    assign rdata = mem[addr];
endmodule

// File: rtl/prot_sram_ctrl.sv
// Top: protected SRAM access controller.
// Assumes req_i is a one-cycle pulse issued only with no access pending.
// In two-cycle mode the request is latched on the first edge and served on the second.
// Responses (ready, error, read data) are registered.
module prot_sram_ctrl
    import psc_pkg::*;
#(
    parameter int BLK_AW = 4,
    localparam int ADDR_W = BLK_AW + 3,
    localparam int ARR_AW = BLK_AW + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              we_i,
    input  logic              ifetch_i,
    input  logic              reloc_i,
    input  logic              frz_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              rdy_o,
    output logic              err_o
);
    logic [DATA_W-1:0] cfg_q;
    logic              s1_valid;
    logic [ADDR_W-1:0] s1_addr;
    logic [DATA_W-1:0] s1_wdata;
    acc_attr_t         s1_attr;

    logic              take1;
    logic              cap;
    logic              eff_valid;
    logic [ADDR_W-1:0] eff_addr;
    logic [DATA_W-1:0] eff_wdata;
    acc_attr_t         eff_attr;
    acc_attr_t         in_attr;

    tgt_e              g_tgt;
    logic              g_err;
    logic              g_arr_wr;
    logic              g_reg_wr;
    logic [DATA_W-1:0] arr_rdata;

    // Bundle the request attributes.
    assign in_attr = '{we: we_i, ifetch: ifetch_i, reloc: reloc_i, frz: frz_i};

    // Decide whether this edge serves a live request or a latched one.
    always_comb begin
        take1     = req_i & ~cfg_q[TWO_B] & ~s1_valid;
        cap       = req_i &  cfg_q[TWO_B] & ~s1_valid;
        eff_valid = s1_valid | take1;
        eff_addr  = s1_valid ? s1_addr  : addr_i;
        eff_wdata = s1_valid ? s1_wdata : wdata_i;
        eff_attr  = s1_valid ? s1_attr  : in_attr;
    end

    // Decode stage used in two-cycle mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0;
            s1_addr  <= '0;
            s1_wdata <= '0;
            s1_attr  <= '0;
        end else begin
            s1_valid <= cap;
            if (cap) begin
                s1_addr  <= addr_i;
                s1_wdata <= wdata_i;
                s1_attr  <= in_attr;
            end
        end
    end

    psc_guard #(.BLK_AW(BLK_AW)) u_guard (
        .addr    (eff_addr),
        .we      (eff_attr.we),
        .ifetch  (eff_attr.ifetch),
        .reloc   (eff_attr.reloc),
        .dis     (cfg_q[DIS_B]),
        .ro_bits (cfg_q[RO_LSB +: NBLK]),
        .do_bits (cfg_q[DO_LSB +: NBLK]),
        .tgt     (g_tgt),
        .err     (g_err),
        .arr_wr  (g_arr_wr),
        .reg_wr  (g_reg_wr)
    );

    psc_cfg_reg u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (eff_valid & g_reg_wr),
        .frz   (eff_attr.frz),
        .wdata (eff_wdata),
        .cfg_q (cfg_q)
    );

    psc_array #(.AW(ARR_AW)) u_arr (
        .clk   (clk),
        .wr_en (eff_valid & g_arr_wr),
        .addr  (eff_addr[ARR_AW-1:0]),
        .wdata (eff_wdata),
        .rdata (arr_rdata)
    );

    // Register the response for the access served this edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdy_o   <= 1'b0;
            err_o   <= 1'b0;
            rdata_o <= '0;
        end else begin
            rdy_o <= eff_valid;
            err_o <= eff_valid & g_err;
            if (eff_valid && !eff_attr.we && !g_err)
                rdata_o <= (g_tgt == TGT_REG) ? cfg_q : arr_rdata;
            else
                rdata_o <= '0;
        end
    end
endmodule

// File: rtl/psc_chk.sv
// Checker for prot_sram_ctrl, attached by bind; observes ports and stage signals.
module psc_chk
    import psc_pkg::*;
#(
    parameter int BLK_AW = 4,
    localparam int ADDR_W = BLK_AW + 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_i,
    input logic              rdy_o,
    input logic              err_o,
    input logic [DATA_W-1:0] cfg_q,
    input logic              s1_valid,
    input logic              eff_valid,
    input logic [ADDR_W-1:0] eff_addr,
    input acc_attr_t         eff_attr,
    input tgt_e              g_tgt
);
    logic [1:0]      blk;
    logic [NBLK-1:0] ro_bits;
    assign blk     = eff_addr[BLK_AW +: 2];
    assign ro_bits = cfg_q[RO_LSB +: NBLK];

    // R12
    err_with_rdy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_o |-> rdy_o);

    // R2
    locked_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_q[LOCK_B] |=> $stable(cfg_q[LOCK_B-1:0]));

    // R3
    lock_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q[LOCK_B] && !(eff_valid && eff_attr.frz)) |=> cfg_q[LOCK_B]);

    // R4
    dis_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_valid && g_tgt == TGT_ARR && cfg_q[DIS_B]) |=> (rdy_o && err_o));

    // R5
    one_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && !cfg_q[TWO_B] && !s1_valid) |=> rdy_o);

    // R5
    two_cyc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i && cfg_q[TWO_B] && !s1_valid) |=> !rdy_o ##1 rdy_o);

    // R7
    ro_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eff_valid && g_tgt == TGT_ARR && eff_attr.we && eff_attr.reloc && ro_bits[blk])
        |=> err_o);
endmodule

bind prot_sram_ctrl psc_chk #(.BLK_AW(BLK_AW)) u_psc_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_i     (req_i),
    .rdy_o     (rdy_o),
    .err_o     (err_o),
    .cfg_q     (cfg_q),
    .s1_valid  (s1_valid),
    .eff_valid (eff_valid),
    .eff_addr  (eff_addr),
    .eff_attr  (eff_attr),
    .g_tgt     (g_tgt)
);

// File: tb/test_prot_sram_ctrl.sv
// Directed bench: one task per scenario, each checks its own results.
module test_prot_sram_ctrl;
    localparam int BLK_AW = 4;
    localparam int ADDR_W = BLK_AW + 3;
    localparam int REGA   = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req = 1'b0, we = 1'b0, ifetch = 1'b0, reloc = 1'b0, frz = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        rdy, err;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [31:0] r_data;
    logic        r_err;
    int          r_cyc;

    always #4 clk = ~clk;

    prot_sram_ctrl #(.BLK_AW(BLK_AW)) i_prot_sram_ctrl (
        .clk(clk), .rst_n(rst_n), .req_i(req), .we_i(we), .ifetch_i(ifetch),
        .reloc_i(reloc), .frz_i(frz), .addr_i(addr), .wdata_i(wdata),
        .rdata_o(rdata), .rdy_o(rdy), .err_o(err)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic acc(input logic w, input logic f, input logic rl, input logic fz,
                       input int a, input logic [31:0] d);
        @(negedge clk);
        req = 1'b1; we = w; ifetch = f; reloc = rl; frz = fz;
        addr = ADDR_W'(a); wdata = d;
        @(negedge clk);
        req = 1'b0;
        r_cyc = 1;
        while (!rdy && r_cyc < 8) begin
            @(negedge clk);
            r_cyc++;
        end
        r_data = rdata;
        r_err  = err;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R10 rdy after reset", {31'b0, rdy}, 32'd0);
        chk("R12 err after reset", {31'b0, err}, 32'd0);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R10 reg reset value", r_data, 32'h0);
        chk("R5 one-cycle reg read", r_cyc, 1);
    endtask

    task automatic t_reg_rw();
        acc(1, 0, 0, 0, REGA, 32'h0000_00A5);
        chk("R1 write no err", {31'b0, r_err}, 0);
        chk("R9 write rdata zero", r_data, 0);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R1 readback A5", r_data, 32'h0000_00A5);
        acc(1, 0, 0, 0, REGA, 32'h1FFF_FF00);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R1 reserved bits zero", r_data, 32'h0);
    endtask

    task automatic t_protect();
        acc(1, 0, 0, 0, REGA, 32'h0000_0042);   // RO block2, DO block1
        acc(1, 0, 0, 0, 35, 32'h1111);
        chk("R7 write allowed reloc=0", {31'b0, r_err}, 0);
        acc(1, 0, 0, 0, 20, 32'hAAAA);
        acc(1, 0, 1, 0, 35, 32'h2222);
        chk("R7 ro write err", {31'b0, r_err}, 1);
        chk("R12 err with rdy", {31'b0, rdy}, 1);
        acc(0, 0, 1, 0, 35, 0);
        chk("R9 errored write left word", r_data, 32'h1111);
        chk("R7 read of ro block ok", {31'b0, r_err}, 0);
        acc(1, 0, 1, 0, 3, 32'h3333);
        chk("R7 write other block ok", {31'b0, r_err}, 0);
        acc(0, 1, 1, 0, 20, 0);
        chk("R8 fetch do block err", {31'b0, r_err}, 1);
        chk("R9 errored read data zero", r_data, 0);
        acc(0, 0, 1, 0, 20, 0);
        chk("R8 data read do block ok", r_data, 32'hAAAA);
        acc(0, 1, 0, 0, 20, 0);
        chk("R8 fetch reloc=0 ok", {31'b0, r_err}, 0);
        acc(0, 1, 1, 0, 35, 0);
        chk("R8 fetch non-do block ok", r_data, 32'h1111);
        acc(1, 0, 0, 0, REGA, 32'h0000_0010);   // RO block0
        acc(1, 0, 1, 0, 15, 32'h5);
        chk("R6 block0 top word err", {31'b0, r_err}, 1);
        acc(1, 0, 1, 0, 16, 32'h5);
        chk("R6 block1 first word ok", {31'b0, r_err}, 0);
        acc(1, 0, 1, 0, 63, 32'h5);
        chk("R6 block3 ok", {31'b0, r_err}, 0);
        acc(1, 0, 0, 0, REGA, 32'h0000_0008);   // DO block3
        acc(0, 1, 1, 0, 48, 0);
        chk("R6 block3 fetch err", {31'b0, r_err}, 1);
        acc(0, 1, 1, 0, 47, 0);
        chk("R6 block2 fetch ok", {31'b0, r_err}, 0);
        acc(1, 0, 0, 0, REGA, 0);
    endtask

    task automatic t_disable();
        acc(1, 0, 0, 0, 5, 32'h55);
        acc(1, 0, 0, 0, REGA, 32'h4000_0000);
        acc(0, 0, 0, 0, 5, 0);
        chk("R4 read err when disabled", {31'b0, r_err}, 1);
        chk("R9 disabled read data", r_data, 0);
        acc(1, 0, 0, 0, 5, 32'h99);
        chk("R4 write err when disabled", {31'b0, r_err}, 1);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R4 reg read while disabled", r_data, 32'h4000_0000);
        chk("R4 reg read no err", {31'b0, r_err}, 0);
        acc(1, 0, 0, 0, REGA, 0);
        acc(0, 0, 0, 0, 5, 0);
        chk("R4 re-enabled, word kept", r_data, 32'h55);
        chk("R4 re-enabled no err", {31'b0, r_err}, 0);
    endtask

    task automatic t_two_cycle();
        acc(1, 0, 0, 0, REGA, 32'h2000_0000);
        chk("R5 setting write one cycle", r_cyc, 1);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R5 two-cycle reg read", r_cyc, 2);
        chk("R5 two-cycle reg value", r_data, 32'h2000_0000);
        acc(1, 0, 0, 0, 7, 32'h77);
        chk("R5 two-cycle array write", r_cyc, 2);
        acc(0, 0, 0, 0, 7, 0);
        chk("R5 two-cycle array read", r_data, 32'h77);
        chk("R5 two-cycle array read cyc", r_cyc, 2);
        acc(0, 0, 0, 0, 100, 0);
        chk("R11 two-cycle unmapped err", {31'b0, r_err}, 1);
        acc(1, 0, 0, 0, REGA, 0);
        chk("R5 clearing write two cycles", r_cyc, 2);
        acc(0, 0, 0, 0, 7, 0);
        chk("R5 back to one cycle", r_cyc, 1);
    endtask

    task automatic t_lock();
        acc(1, 0, 0, 0, REGA, 32'h8000_0010);
        acc(1, 0, 0, 0, REGA, 32'h0);
        chk("R2 locked write no err", {31'b0, r_err}, 0);
        chk("R2 locked write ready", {31'b0, rdy}, 1);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R3 lock kept without freeze", r_data, 32'h8000_0010);
        acc(1, 0, 0, 1, REGA, 32'h8000_0000);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R2 freeze write lock=1 ignored", r_data, 32'h8000_0010);
        acc(1, 0, 0, 1, REGA, 32'h0000_0003);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R3 freeze clears only lock", r_data, 32'h0000_0010);
        acc(1, 0, 0, 0, REGA, 32'h0000_0001);
        acc(0, 0, 0, 0, REGA, 0);
        chk("R1 writable after unlock", r_data, 32'h0000_0001);
        acc(1, 0, 0, 0, REGA, 0);
    endtask

    task automatic t_unmapped();
        acc(0, 0, 0, 0, REGA + 1, 0);
        chk("R11 read above reg err", {31'b0, r_err}, 1);
        acc(1, 0, 0, 0, 127, 32'h1);
        chk("R11 write above reg err", {31'b0, r_err}, 1);
    endtask

    task automatic t_reset_reenable();
        acc(1, 0, 0, 0, REGA, 32'hC000_00FF);
        do_reset();
        acc(0, 0, 0, 0, REGA, 0);
        chk("R10 reset clears locked reg", r_data, 0);
        acc(1, 0, 1, 0, 40, 32'hBEEF);
        chk("R10 array enabled after reset", {31'b0, r_err}, 0);
        acc(0, 1, 1, 0, 40, 0);
        chk("R10 no protection after reset", r_data, 32'hBEEF);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_reg_rw();
        t_protect();
        t_disable();
        t_two_cycle();
        t_lock();
        t_unmapped();
        t_reset_reenable();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule